// File: doc/BRIEF.md
# UART Transmit Buffering and Line Status Flags

This block owns the transmit-side buffering of a UART and the three status flags that software polls to pace its traffic. Characters written by the processor either land in a single holding register or, with FIFO mode enabled, in a 64-entry transmit queue. From there they are handed to an external transmit shift register through a one-cycle load strobe. The shift register reports back with a done pulse once the character has left the line.

The block also follows the error tags of the characters sitting in a separate receive FIFO. That FIFO pushes each character together with its parity, framing and break tags, and it reports whether each popped character was tagged. From this the block keeps a summary flag. The flag stays up until every tagged character has been popped, because the status word has no read side effect.

The status word is 32 bits wide and carries only these flags. Every other bit reads 0.

Top module: `uart_line_status`

## Requirements
- R1: After reset `status_o` reads 0x00000060. Bit 7 is the receive error summary, bit 6 is transmitter-empty and bit 5 is transmit-request. All bits other than 7, 6 and 5 always read 0.
- R2: In non-FIFO mode, bit 6 is 1 exactly when the holding register is empty and the shift register is idle.
- R3: In non-FIFO mode, bit 5 goes to 1 on the cycle after the holding register hands its character to the shift register. A processor write clears bit 5 on the following cycle. When a write and a handoff fall in the same cycle, the write wins: bit 5 ends at 0 and the new character stays held.
- R4: `sh_load_o` pulses for one cycle, with the character on `sh_data_o`, when a character is waiting and the shift register is idle or asserts `sh_done_i` in that same cycle. Characters leave in the order they were written.
- R5: In FIFO mode, bit 6 is 1 exactly when the transmit FIFO is empty and the shift register is idle.
- R6: In FIFO mode, bit 5 is 1 while the transmit FIFO holds 32 characters or fewer, and 0 while it holds more than 32.
- R7: The transmit FIFO holds 64 characters. A write made while it is full is discarded.
- R8: A `tx_fifo_clr_i` pulse empties the transmit FIFO on the next edge, so bit 5 reads 1 afterwards. It does not abort a character already in the shift register.
- R9: In non-FIFO mode, bit 7 reads 0 whatever the receive tags are.
- R10: In FIFO mode, bit 7 is 1 while at least one error-tagged character remains in the receive FIFO. Reading status never clears it; it drops only when the last tagged character is popped.
- R11: The tagged-character count rises on a push with any of parity, framing or break set, and falls on a pop marked tagged. A tagged push and a tagged pop in the same cycle leave it unchanged. `rx_fifo_clr_i` sets it to 0.
- R12: A change of `fifo_en_i` discards the contents of the transmit FIFO and the holding register, sets non-FIFO bit 5 to 1, and leaves a character in the shift register untouched. A write in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1 selects FIFO mode |
| tx_fifo_clr_i | input | 1 | Empties the transmit FIFO |
| rx_fifo_clr_i | input | 1 | Receive FIFO reset; clears the tagged count |
| tx_wr_i | input | 1 | Processor write of a transmit character |
| tx_data_i | input | 8 | Transmit character |
| sh_load_o | output | 1 | Load strobe to the shift register |
| sh_data_o | output | 8 | Character handed to the shift register |
| sh_done_i | input | 1 | Shift register finished its character |
| rx_push_i | input | 1 | Receive FIFO push |
| rx_perr_i | input | 1 | Parity error tag of the pushed character |
| rx_ferr_i | input | 1 | Framing error tag of the pushed character |
| rx_brk_i | input | 1 | Break tag of the pushed character |
| rx_pop_i | input | 1 | Receive FIFO pop |
| rx_pop_tag_i | input | 1 | The popped character carried an error tag |
| status_o | output | 32 | Line status word |

## Verification
Two sets of events can land on the same clock edge.

On the transmit side, a processor write can coincide with the handoff of the held character. The bench provokes this with a table row that writes while `sh_load_o` is pulsing. It then checks that the old character went out, that bit 5 stays 0 and that the new character leaves on the next done. The shift register's done pulse also meets a fresh load in back-to-back rows.

On the receive side, a tagged push and a tagged pop are driven together while exactly one tagged character is present. Bit 7 must still read 1 afterwards, and it must clear after one further tagged pop. This exposes a count that moves either way in the shared cycle.

// File: rtl/uart_lsr_pkg.sv
`timescale 1ns/1ps
package uart_lsr_pkg;
  localparam int unsigned STAT_W    = 32;
  localparam int unsigned BIT_FIFOE = 7;
  localparam int unsigned BIT_TEMT  = 6;
  localparam int unsigned BIT_TDRQ  = 5;

  typedef struct packed {
    logic fifo_err;
    logic tx_empty;
    logic tx_req;
  } lsr_flags_t;

  function automatic logic [STAT_W-1:0] pack_status(input lsr_flags_t f);
    logic [STAT_W-1:0] s;
    s            = '0;
    s[BIT_FIFOE] = f.fifo_err;
    s[BIT_TEMT]  = f.tx_empty;
    s[BIT_TDRQ]  = f.tx_req;
    return s;
  endfunction
endpackage

// File: rtl/lsr_tx_fifo.sv
`timescale 1ns/1ps
module lsr_tx_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       push_i,
  input  logic [DW-1:0]              data_i,
  input  logic                       pop_i,
  output logic [DW-1:0]              data_o,
  output logic [$clog2(DEPTH):0]     count_o,
  output logic                       empty_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          full, push_ok, pop_ok;

  assign full    = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i & ~full & ~clr_i;  // writes while full are dropped
  assign pop_ok  = pop_i & ~empty_o & ~clr_i;
  assign data_o  = mem_q[rptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= wptr_q + AW'(1);
      if (pop_ok)  rptr_q <= rptr_q + AW'(1);
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= FULL_CNT);
  assert_full_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == FULL_CNT) && push_i && !pop_i && !clr_i |=> count_o == $past(count_o));
  assert_clr_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o);
endmodule

// File: rtl/lsr_tx_ctrl.sv
`timescale 1ns/1ps
module lsr_tx_ctrl #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_mode_i,
  input  logic          flush_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [DW-1:0] fifo_data_i,
  input  logic          fifo_empty_i,
  output logic          fifo_pop_o,
  input  logic          sh_done_i,
  output logic          sh_load_o,
  output logic [DW-1:0] sh_data_o,
  output logic          hold_full_o,
  output logic          sh_busy_o,
  output logic          nf_req_o
);
  logic [DW-1:0] hold_q;
  logic          hold_full_q, busy_q, req_q;
  logic          src_avail, nf_wr, nf_load;

  assign src_avail  = fifo_mode_i ? ~fifo_empty_i : hold_full_q;
  // back-to-back: a done pulse frees the shift register for the same edge
  assign sh_load_o  = src_avail & (~busy_q | sh_done_i) & ~flush_i;
  assign sh_data_o  = fifo_mode_i ? fifo_data_i : hold_q;
  assign fifo_pop_o = sh_load_o & fifo_mode_i;
  assign nf_wr      = wr_i & ~fifo_mode_i & ~flush_i;
  assign nf_load    = sh_load_o & ~fifo_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      req_q       <= 1'b1;
    end else if (flush_i) begin
      hold_full_q <= 1'b0;
      req_q       <= 1'b1;
    end else if (nf_wr) begin
      hold_q      <= wr_data_i;
      hold_full_q <= 1'b1;
      req_q       <= 1'b0;   // write wins over a concurrent handoff
    end else if (nf_load) begin
      hold_full_q <= 1'b0;
      req_q       <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        busy_q <= 1'b0;
    else if (sh_load_o) busy_q <= 1'b1;
    else if (sh_done_i) busy_q <= 1'b0;
  end

  assign hold_full_o = hold_full_q;
  assign sh_busy_o   = busy_q;
  assign nf_req_o    = req_q;

  assert_load_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_load_o |=> sh_busy_o);
  assert_wr_clears_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !fifo_mode_i && !flush_i |=> !nf_req_o && hold_full_o);
  assert_load_sets_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_load_o && !fifo_mode_i && !wr_i |=> nf_req_o);
  assert_flush_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !hold_full_o && nf_req_o);
endmodule

// File: rtl/lsr_rx_err_cnt.sv
`timescale 1ns/1ps
module lsr_rx_err_cnt #(
  parameter int unsigned DEPTH = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     push_tag_i,
  input  logic                     pop_tag_i,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                     any_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] MAX_CNT = CW'(DEPTH);

  logic [CW-1:0] cnt_q;
  logic          inc, dec;

  assign inc = push_tag_i & ~pop_tag_i & (cnt_q != MAX_CNT);
  assign dec = pop_tag_i & ~push_tag_i & (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc)    cnt_q <= cnt_q + CW'(1);
    else if (dec)    cnt_q <= cnt_q - CW'(1);
  end

  assign count_o = cnt_q;
  assign any_o   = (cnt_q != '0);

  assert_inc_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_tag_i && !pop_tag_i && !clr_i && (count_o < MAX_CNT)
    |=> count_o == $past(count_o) + CW'(1));
  assert_both_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_tag_i && pop_tag_i && !clr_i |=> $stable(count_o));
  assert_clr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> count_o == '0);
endmodule

// File: rtl/uart_line_status.sv
`timescale 1ns/1ps
module uart_line_status
  import uart_lsr_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned TX_DEPTH = 64,
  parameter int unsigned RX_DEPTH = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_en_i,
  input  logic              tx_fifo_clr_i,
  input  logic              rx_fifo_clr_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              sh_load_o,
  output logic [DATA_W-1:0] sh_data_o,
  input  logic              sh_done_i,
  input  logic              rx_push_i,
  input  logic              rx_perr_i,
  input  logic              rx_ferr_i,
  input  logic              rx_brk_i,
  input  logic              rx_pop_i,
  input  logic              rx_pop_tag_i,
  output logic [STAT_W-1:0] status_o
);
  localparam int unsigned TX_CW = $clog2(TX_DEPTH) + 1;
  localparam int unsigned RX_CW = $clog2(RX_DEPTH + 1);
  localparam logic [TX_CW-1:0] HALF_CNT = TX_CW'(TX_DEPTH / 2);

  logic              fifo_en_q, flush;
  logic              fifo_push, fifo_pop, fifo_empty;
  logic [DATA_W-1:0] fifo_data;
  logic [TX_CW-1:0]  fifo_cnt;
  logic              hold_full, sh_busy, nf_req;
  logic [RX_CW-1:0]  err_cnt;
  logic              err_any, push_tag, pop_tag;
  lsr_flags_t        flags;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fifo_en_q <= 1'b0;
    else         fifo_en_q <= fifo_en_i;
  end

  assign flush     = fifo_en_i ^ fifo_en_q;
  assign fifo_push = tx_wr_i & fifo_en_i & ~flush;

  lsr_tx_fifo #(.DW(DATA_W), .DEPTH(TX_DEPTH)) i_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (tx_fifo_clr_i | flush),
    .push_i  (fifo_push),
    .data_i  (tx_data_i),
    .pop_i   (fifo_pop),
    .data_o  (fifo_data),
    .count_o (fifo_cnt),
    .empty_o (fifo_empty)
  );

  lsr_tx_ctrl #(.DW(DATA_W)) i_tx_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fifo_mode_i  (fifo_en_i),
    .flush_i      (flush | (tx_fifo_clr_i & fifo_en_i)),
    .wr_i         (tx_wr_i),
    .wr_data_i    (tx_data_i),
    .fifo_data_i  (fifo_data),
    .fifo_empty_i (fifo_empty),
    .fifo_pop_o   (fifo_pop),
    .sh_done_i    (sh_done_i),
    .sh_load_o    (sh_load_o),
    .sh_data_o    (sh_data_o),
    .hold_full_o  (hold_full),
    .sh_busy_o    (sh_busy),
    .nf_req_o     (nf_req)
  );

  assign push_tag = rx_push_i & (rx_perr_i | rx_ferr_i | rx_brk_i);
  assign pop_tag  = rx_pop_i & rx_pop_tag_i;

  lsr_rx_err_cnt #(.DEPTH(RX_DEPTH)) i_rx_err (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (rx_fifo_clr_i),
    .push_tag_i (push_tag),
    .pop_tag_i  (pop_tag),
    .count_o    (err_cnt),
    .any_o      (err_any)
  );

  always_comb begin
    flags.fifo_err = fifo_en_i & err_any;
    if (fifo_en_i) begin
      flags.tx_empty = ~sh_busy & fifo_empty;
      flags.tx_req   = (fifo_cnt <= HALF_CNT);
    end else begin
      flags.tx_empty = ~sh_busy & ~hold_full;
      flags.tx_req   = nf_req;
    end
  end

  assign status_o = pack_status(flags);

  assert_fifoe_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i |-> !status_o[BIT_FIFOE]);
  assert_fifoe_on_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_i && (err_cnt != '0) |-> status_o[BIT_FIFOE]);
  assert_temt_after_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_load_o |=> !status_o[BIT_TEMT]);
  assert_req_above_half_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_i && (fifo_cnt > HALF_CNT) |-> !status_o[BIT_TDRQ]);
endmodule

// File: tb/test_uart_line_status.sv
`timescale 1ns/1ps
module test_uart_line_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_en = 1'b0, tx_clr = 1'b0, rx_clr = 1'b0;
  logic        tx_wr = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        sh_load;
  logic [7:0]  sh_data;
  logic        sh_done = 1'b0;
  logic        rx_push = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
  logic        rx_pop = 1'b0, rx_pop_tag = 1'b0;
  logic [31:0] status;
  int          n_chk = 0, n_err = 0;

  always #10 clk = ~clk;  // 50 MHz

  uart_line_status i_uart_line_status (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .tx_fifo_clr_i(tx_clr),
    .rx_fifo_clr_i(rx_clr), .tx_wr_i(tx_wr), .tx_data_i(tx_data),
    .sh_load_o(sh_load), .sh_data_o(sh_data), .sh_done_i(sh_done),
    .rx_push_i(rx_push), .rx_perr_i(rx_perr), .rx_ferr_i(rx_ferr), .rx_brk_i(rx_brk),
    .rx_pop_i(rx_pop), .rx_pop_tag_i(rx_pop_tag), .status_o(status)
  );

  // {wr, data, done, exp_load, exp_ldata, exp_temt, exp_tdrq}, non-FIFO mode
  localparam logic [20:0] VEC [12] = '{
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1},
    {1'b1, 8'hA1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1},
    {1'b0, 8'h00, 1'b0, 1'b1, 8'hA1, 1'b0, 1'b0},
    {1'b1, 8'hB2, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b1, 8'hB2, 1'b0, 1'b0},
    {1'b1, 8'hC3, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1},
    {1'b1, 8'hD4, 1'b0, 1'b1, 8'hC3, 1'b0, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b1, 8'hD4, 1'b0, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1},
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // start a cycle: wait for the falling edge and clear every pulse input
  task automatic cyc();
    @(negedge clk);
    tx_wr = 1'b0; tx_data = '0; sh_done = 1'b0; tx_clr = 1'b0; rx_clr = 1'b0;
    rx_push = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
    rx_pop = 1'b0; rx_pop_tag = 1'b0;
  endtask

  task automatic settle();
    #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int nxt;
    int mcnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(); settle();
    chk("R1 reset status", status, 32'h60);
    chk("R4 no load after reset", {31'b0, sh_load}, 32'd0);

    // non-FIFO table walk
    foreach (VEC[i]) begin
      cyc();
      tx_wr = VEC[i][20]; tx_data = VEC[i][19:12]; sh_done = VEC[i][11];
      settle();
      chk($sformatf("R4 load row %0d", i), {31'b0, sh_load}, {31'b0, VEC[i][10]});
      if (VEC[i][10]) chk($sformatf("R4 data row %0d", i), {24'b0, sh_data}, {24'b0, VEC[i][9:2]});
      chk($sformatf("R2 temt row %0d", i), {31'b0, status[6]}, {31'b0, VEC[i][1]});
      chk($sformatf("R3 tdrq row %0d", i), {31'b0, status[5]}, {31'b0, VEC[i][0]});
    end

    // R12: held character discarded on mode change, shift register keeps going
    cyc(); tx_wr = 1'b1; tx_data = 8'h11; settle();
    cyc(); settle();
    chk("R4 load before switch", {31'b0, sh_load}, 32'd1);
    cyc(); tx_wr = 1'b1; tx_data = 8'h22; settle();
    cyc(); fifo_en = 1'b1; settle();
    chk("R12 no load in switch cycle", {31'b0, sh_load}, 32'd0);
    cyc(); settle();
    chk("R12 shift kept, temt 0", {31'b0, status[6]}, 32'd0);
    chk("R12 tdrq after switch", {31'b0, status[5]}, 32'd1);
    cyc(); sh_done = 1'b1; settle();
    chk("R12 held char discarded", {31'b0, sh_load}, 32'd0);
    cyc(); settle();
    chk("R5 fifo mode idle status", status, 32'h60);

    // fill: 33 writes leave 32 queued (first goes to shift)
    for (int i = 0; i < 33; i++) begin
      cyc(); tx_wr = 1'b1; tx_data = 8'(i); settle();
    end
    cyc(); settle();
    chk("R6 tdrq at 32 entries", {31'b0, status[5]}, 32'd1);
    chk("R5 temt with data", {31'b0, status[6]}, 32'd0);
    cyc(); tx_wr = 1'b1; tx_data = 8'd33; settle();
    cyc(); settle();
    chk("R6 tdrq at 33 entries", {31'b0, status[5]}, 32'd0);
    for (int i = 34; i < 74; i++) begin
      cyc(); tx_wr = 1'b1; tx_data = 8'(i); settle();
    end
    // drain: 64 queued characters expected, indices 1..64
    mcnt = 64; nxt = 1;
    for (int i = 0; i < 65; i++) begin
      cyc(); sh_done = 1'b1; settle();
      chk("R6 tdrq during drain", {31'b0, status[5]}, {31'b0, (mcnt <= 32)});
      if (mcnt > 0) begin
        if (sh_load !== 1'b1 || sh_data !== 8'(nxt)) begin
          chk("R7 drain order", {23'b0, sh_load, sh_data}, {23'b0, 1'b1, 8'(nxt)});
        end else n_chk++;
        mcnt--; nxt++;
      end else begin
        chk("R7 nothing beyond 64", {31'b0, sh_load}, 32'd0);
      end
    end
    cyc(); settle();
    chk("R5 empty after drain", {31'b0, status[6]}, 32'd1);
    chk("R7 chars delivered", nxt, 65);

    // R8: clear above half, shift not aborted
    for (int i = 0; i < 40; i++) begin
      cyc(); tx_wr = 1'b1; tx_data = 8'(i); settle();
    end
    cyc(); settle();
    chk("R6 tdrq with 39 queued", {31'b0, status[5]}, 32'd0);
    cyc(); tx_clr = 1'b1; settle();
    cyc(); settle();
    chk("R8 tdrq after clear", {31'b0, status[5]}, 32'd1);
    chk("R8 shift still busy", {31'b0, status[6]}, 32'd0);
    cyc(); sh_done = 1'b1; settle();
    chk("R8 fifo empty no load", {31'b0, sh_load}, 32'd0);
    cyc(); settle();
    chk("R8 temt after done", {31'b0, status[6]}, 32'd1);

    // receive error summary, FIFO mode
    cyc(); rx_push = 1'b1; rx_perr = 1'b1; settle();
    cyc(); settle();
    chk("R10 flag after tagged push", {31'b0, status[7]}, 32'd1);
    cyc(); rx_push = 1'b1; rx_brk = 1'b1; rx_pop = 1'b1; rx_pop_tag = 1'b1; settle();
    cyc(); settle();
    chk("R11 push and pop same cycle", {31'b0, status[7]}, 32'd1);
    cyc(); rx_push = 1'b1; rx_pop = 1'b1; settle();
    repeat (3) begin
      cyc(); settle();
      chk("R10 status read keeps flag", {31'b0, status[7]}, 32'd1);
    end
    cyc(); rx_pop = 1'b1; rx_pop_tag = 1'b1; settle();
    cyc(); settle();
    chk("R10 clears after last tagged pop", {31'b0, status[7]}, 32'd0);
    cyc(); rx_push = 1'b1; rx_ferr = 1'b1; settle();
    cyc(); rx_push = 1'b1; rx_brk = 1'b1; settle();
    cyc(); rx_pop = 1'b1; rx_pop_tag = 1'b1; settle();
    cyc(); settle();
    chk("R11 one tagged left", {31'b0, status[7]}, 32'd1);
    cyc(); rx_clr = 1'b1; settle();
    cyc(); settle();
    chk("R11 receive clear", {31'b0, status[7]}, 32'd0);
    cyc(); rx_push = 1'b1; rx_perr = 1'b1; settle();
    cyc(); fifo_en = 1'b0; settle();
    chk("R9 flag masked in non-FIFO", {31'b0, status[7]}, 32'd0);
    cyc(); settle();
    chk("R1 status word non-FIFO", status, 32'h60);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule